// File: doc/BRIEF.md
# Exception return sequencer

This block carries out the return-from-exception step of a 32-bit processor whose memory is organised in 16-bit words. When `start` is pulsed it takes the current supervisor stack pointer and the processor's own version byte. It then walks the stack frame at that address through a word-wide memory port that uses a request/acknowledge handshake.

The first word fetched is the frame's format word. Its top four bits decide what follows: a short frame, a long frame, a bus-fault frame, or an unknown code, which is rejected at once. Short and long frames give back the status register and the program counter. A bus-fault frame is read completely. Its version byte is compared with the processor's own, and if its status word says the fault struck during exception processing, that word is written back before the return completes.

A successful return loads the status register, the program counter and the advanced stack pointer in a single edge, together with a one-cycle `done` pulse. A rejected frame raises a format-error request and a failed read raises a bus-error request. In both cases the outputs and the frame in memory are left untouched. A failed write-back halts the sequencer until reset.

Top module: `erf_return_unit`

## Requirements
- R1: After reset, `sr_out`, `pc_out` and `ssp_out` are zero and `done`, `exc_valid`, `busy` and `halt` are low.
- R2: The first access of a return is a read of the word at SSP+6. Its bits 15:12 select the frame type: 0x0 short, 0x2 long, 0xC bus-fault. Any other value ends the return with `exc_valid` and `exc_code` = 1 (format error).
- R3: For a short frame, SR is taken from SSP+0 and PC from SSP+2 (upper half) and SSP+4 (lower half); the stack pointer becomes SSP+8.
- R4: For a long frame, SR and PC are taken from the same words and the stack pointer becomes SSP+12.
- R5: For a bus-fault frame, all twelve words are read. Bits 15:8 of the word at SSP+14 must equal `ver_in`, otherwise the return ends with a format error. A valid frame gives a stack pointer of SSP+24.
- R6: If bit 15 of the bus-fault word at SSP+8 is set, that word is written back to SSP+8 with bit 15 cleared before `done`. Otherwise no write occurs.
- R7: A read answered with `mem_err` ends the return with `exc_valid` and `exc_code` = 2 (bus error).
- R8: A write-back answered with `mem_err` sets `halt`. From then on, until reset, there is no `done`, no exception, no memory request and no response to `start`.
- R9: A return that ends in a format or bus error writes no memory and leaves `sr_out`, `pc_out` and `ssp_out` unchanged.
- R10: `done` is high for exactly one cycle per successful return. `sr_out`, `pc_out` and `ssp_out` change only in the cycle in which `done` is high.
- R11: `start` is ignored while `busy` is high.
- R12: Once raised, `mem_req` stays high with a steady `mem_addr` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a return |
| ssp_in | input | ADDR_W | Supervisor stack pointer at start |
| ver_in | input | VER_W | Processor version byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completed this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Access failed, valid with `mem_ack` |
| sr_out | output | 16 | Restored status register |
| pc_out | output | ADDR_W | Restored program counter |
| ssp_out | output | ADDR_W | Stack pointer after the frame is released |
| done | output | 1 | One-cycle success strobe |
| exc_valid | output | 1 | One-cycle exception request |
| exc_code | output | 2 | 1 = format error, 2 = bus error |
| busy | output | 1 | A return is in progress |
| halt | output | 1 | Sequencer stopped after a write-back fault |

## Verification
The bench builds the block with its default 32-bit addresses and an 8-bit version field. This makes the split of the program counter across two stack words observable, as well as the exact version byte at the top of the word at SSP+14, where a single-bit mismatch must still be rejected. Frames are placed near the end of a small word memory so that 24-byte releases are seen in full. Alternate-cycle stalls on the acknowledge exercise the hold rule on the request.

// File: rtl/erf_pkg.sv
package erf_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = 4;

    // Format codes in the top nibble of the format word
    localparam logic [3:0] FMT_SHORT = 4'h0;
    localparam logic [3:0] FMT_LONG  = 4'h2;
    localparam logic [3:0] FMT_FAULT = 4'hC;

    // Word positions inside a frame
    localparam logic [IDX_W-1:0] IDX_SR         = 4'd0;
    localparam logic [IDX_W-1:0] IDX_PC_HI      = 4'd1;
    localparam logic [IDX_W-1:0] IDX_PC_LO      = 4'd2;
    localparam logic [IDX_W-1:0] IDX_FMT        = 4'd3;
    localparam logic [IDX_W-1:0] IDX_SSW        = 4'd4;
    localparam logic [IDX_W-1:0] IDX_VER        = 4'd7;
    localparam logic [IDX_W-1:0] IDX_SHORT_LAST = 4'd2;
    localparam logic [IDX_W-1:0] IDX_FAULT_LAST = 4'd11;

    localparam int REWRITE_BIT = 15;

    typedef enum logic [1:0] {
        KIND_SHORT = 2'd0,
        KIND_LONG  = 2'd1,
        KIND_FAULT = 2'd2
    } frame_kind_e;

    typedef enum logic [1:0] {
        EXC_NONE   = 2'd0,
        EXC_FORMAT = 2'd1,
        EXC_BUS    = 2'd2
    } exc_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FMT,
        ST_BODY,
        ST_CHECK,
        ST_REWRITE,
        ST_HALT
    } seq_state_e;

    typedef struct packed {
        logic             ok;
        frame_kind_e      kind;
        logic [IDX_W-1:0] last_idx;
    } fmt_info_t;

    function automatic logic [4:0] frame_bytes(frame_kind_e k);
        case (k)
            KIND_LONG:  return 5'd12;
            KIND_FAULT: return 5'd24;
            default:    return 5'd8;
        endcase
    endfunction

    function automatic fmt_info_t decode_format(logic [3:0] code);
        fmt_info_t r;
        r.ok       = 1'b1;
        r.kind     = KIND_SHORT;
        r.last_idx = IDX_SHORT_LAST;
        case (code)
            FMT_SHORT: r.kind = KIND_SHORT;
            FMT_LONG:  r.kind = KIND_LONG;
            FMT_FAULT: begin
                r.kind     = KIND_FAULT;
                r.last_idx = IDX_FAULT_LAST;
            end
            default:   r.ok = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/erf_decode.sv
module erf_decode
    import erf_pkg::*;
#(
    parameter int VER_W = 8
) (
    input  logic [3:0]       fmt_code,
    input  logic [VER_W-1:0] ver_seen,
    input  logic [VER_W-1:0] ver_own,
    output fmt_info_t        info,
    output logic             ver_ok
);

    assign info   = decode_format(fmt_code);
    assign ver_ok = (ver_seen == ver_own);

endmodule

// File: rtl/erf_ctx_regs.sv
module erf_ctx_regs
    import erf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [WORD_W-1:0] new_sr,
    input  logic [ADDR_W-1:0] new_pc,
    input  logic [ADDR_W-1:0] new_ssp,
    output logic [WORD_W-1:0] sr_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] ssp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            pc_q  <= '0;
            ssp_q <= '0;
        end else if (commit) begin
            sr_q  <= new_sr;
            pc_q  <= new_pc;
            ssp_q <= new_ssp;
        end
    end

endmodule

// File: rtl/erf_fsm.sv
module erf_fsm
    import erf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VER_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] ssp_in,
    input  logic [VER_W-1:0]  ver_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              commit,
    output logic [WORD_W-1:0] new_sr,
    output logic [ADDR_W-1:0] new_pc,
    output logic [ADDR_W-1:0] new_ssp,
    output logic              done,
    output logic              exc_valid,
    output logic [1:0]        exc_code,
    output logic              busy,
    output logic              halt
);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] base_q;
    logic [VER_W-1:0]  ver_q;
    logic [VER_W-1:0]  ver_seen_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  rd_idx;
    fmt_info_t         info;
    fmt_info_t         info_q;
    logic              ver_ok;
    logic [WORD_W-1:0] sr_q, pc_hi_q, pc_lo_q, ssw_q;
    logic              done_q, exc_valid_q, halt_q;
    exc_code_e         exc_code_q;
    logic              check_pass;

    erf_decode #(.VER_W(VER_W)) u_decode (
        .fmt_code (mem_rdata[WORD_W-1 -: 4]),
        .ver_seen (ver_seen_q),
        .ver_own  (ver_q),
        .info     (info),
        .ver_ok   (ver_ok)
    );

    always_comb begin
        if (state_q == ST_FMT)          rd_idx = IDX_FMT;
        else if (state_q == ST_REWRITE) rd_idx = IDX_SSW;
        else                            rd_idx = idx_q;
    end

    assign mem_req   = (state_q == ST_FMT) || (state_q == ST_BODY) || (state_q == ST_REWRITE);
    assign mem_we    = (state_q == ST_REWRITE);
    assign mem_addr  = base_q + ADDR_W'({rd_idx, 1'b0});
    assign mem_wdata = ssw_q & ~(WORD_W'(1) << REWRITE_BIT);

    assign check_pass = (state_q == ST_CHECK) &&
                        ((info_q.kind != KIND_FAULT) || (ver_ok && !ssw_q[REWRITE_BIT]));
    assign commit  = check_pass || ((state_q == ST_REWRITE) && mem_ack && !mem_err);
    assign new_sr  = sr_q;
    assign new_pc  = ADDR_W'({pc_hi_q, pc_lo_q});
    assign new_ssp = base_q + ADDR_W'(frame_bytes(info_q.kind));

    assign done      = done_q;
    assign exc_valid = exc_valid_q;
    assign exc_code  = exc_valid_q ? exc_code_q : EXC_NONE;
    assign busy      = (state_q != ST_IDLE) && (state_q != ST_HALT);
    assign halt      = halt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            base_q      <= '0;
            ver_q       <= '0;
            ver_seen_q  <= '0;
            idx_q       <= '0;
            info_q      <= '0;
            sr_q        <= '0;
            pc_hi_q     <= '0;
            pc_lo_q     <= '0;
            ssw_q       <= '0;
            done_q      <= 1'b0;
            exc_valid_q <= 1'b0;
            exc_code_q  <= EXC_NONE;
            halt_q      <= 1'b0;
        end else begin
            done_q      <= 1'b0;
            exc_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q  <= ssp_in;
                        ver_q   <= ver_in;
                        state_q <= ST_FMT;
                    end
                end
                ST_FMT: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            exc_valid_q <= 1'b1;
                            exc_code_q  <= EXC_BUS;
                            state_q     <= ST_IDLE;
                        end else if (!info.ok) begin
                            exc_valid_q <= 1'b1;
                            exc_code_q  <= EXC_FORMAT;
                            state_q     <= ST_IDLE;
                        end else begin
                            info_q  <= info;
                            idx_q   <= IDX_SR;
                            state_q <= ST_BODY;
                        end
                    end
                end
                ST_BODY: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            exc_valid_q <= 1'b1;
                            exc_code_q  <= EXC_BUS;
                            state_q     <= ST_IDLE;
                        end else begin
                            if (idx_q == IDX_SR)    sr_q       <= mem_rdata;
                            if (idx_q == IDX_PC_HI) pc_hi_q    <= mem_rdata;
                            if (idx_q == IDX_PC_LO) pc_lo_q    <= mem_rdata;
                            if (idx_q == IDX_SSW)   ssw_q      <= mem_rdata;
                            if (idx_q == IDX_VER)   ver_seen_q <= mem_rdata[WORD_W-1 -: VER_W];
                            if (idx_q == info_q.last_idx) state_q <= ST_CHECK;
                            else idx_q <= (idx_q == IDX_PC_LO) ? IDX_SSW : idx_q + 1'b1;
                        end
                    end
                end
                ST_CHECK: begin
                    if (check_pass) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (!ver_ok) begin
                        exc_valid_q <= 1'b1;
                        exc_code_q  <= EXC_FORMAT;
                        state_q     <= ST_IDLE;
                    end else begin
                        state_q <= ST_REWRITE;
                    end
                end
                ST_REWRITE: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            halt_q  <= 1'b1;
                            state_q <= ST_HALT;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_HALT;
            endcase
        end
    end

    // R10: the success strobe never lasts two cycles
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R12: a pending access keeps its request and address
    a_r12_addr_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R8: halt is sticky until reset
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halt_q |=> halt_q);

    // R8: a halted sequencer is silent
    a_r8_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halt_q |-> (!mem_req && !done_q && !exc_valid_q));

    // R9: an error ending is never also a success
    a_r9_exc_not_done: assert property (@(posedge clk) disable iff (rst)
        exc_valid_q |-> !done_q);

endmodule

// File: rtl/erf_return_unit.sv
module erf_return_unit
    import erf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VER_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] ssp_in,
    input  logic [VER_W-1:0]  ver_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_err,
    output logic [15:0]       sr_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] ssp_out,
    output logic              done,
    output logic              exc_valid,
    output logic [1:0]        exc_code,
    output logic              busy,
    output logic              halt
);

    logic              commit;
    logic [WORD_W-1:0] new_sr;
    logic [ADDR_W-1:0] new_pc;
    logic [ADDR_W-1:0] new_ssp;

    erf_fsm #(.ADDR_W(ADDR_W), .VER_W(VER_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ssp_in    (ssp_in),
        .ver_in    (ver_in),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_err   (mem_err),
        .commit    (commit),
        .new_sr    (new_sr),
        .new_pc    (new_pc),
        .new_ssp   (new_ssp),
        .done      (done),
        .exc_valid (exc_valid),
        .exc_code  (exc_code),
        .busy      (busy),
        .halt      (halt)
    );

    erf_ctx_regs #(.ADDR_W(ADDR_W)) u_ctx (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .new_sr  (new_sr),
        .new_pc  (new_pc),
        .new_ssp (new_ssp),
        .sr_q    (sr_out),
        .pc_q    (pc_out),
        .ssp_q   (ssp_out)
    );

    // R10: the restored context moves only together with the success strobe
    a_r10_ctx_with_done: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(sr_out) && $stable(pc_out) && $stable(ssp_out)));

    // R9: an exception request leaves the context as it was
    a_r9_exc_keeps_ctx: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> ($stable(ssp_out) && $stable(pc_out)));

endmodule

// File: tb/erf_return_unit_tb_top.sv
`timescale 1ns/1ps
module erf_return_unit_tb_top;

    localparam int P_NONE = 0, P_DONE = 1, P_FMT = 2, P_BUS = 3, P_HALT = 4;
    localparam logic [7:0] OWN_VER = 8'h5A;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1, start = 1'b0;
    logic [31:0] ssp_in = '0;
    logic [7:0]  ver_in = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] sr_out;
    logic [31:0] pc_out, ssp_out;
    logic        done, exc_valid, busy, halt;
    logic [1:0]  exc_code;

    erf_return_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .ssp_in(ssp_in), .ver_in(ver_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .sr_out(sr_out), .pc_out(pc_out), .ssp_out(ssp_out),
        .done(done), .exc_valid(exc_valid), .exc_code(exc_code), .busy(busy), .halt(halt)
    );

    int vectors = 0, miscompares = 0;
    int pend = P_NONE;
    logic [15:0] pend_sr = '0, exp_sr = '0;
    logic [31:0] pend_pc = '0, exp_pc = '0, pend_ssp = '0, exp_ssp = '0;

    logic [15:0] mem [0:255];
    logic [31:0] err_addr = '1;
    bit          err_write = 1'b0, stall_en = 1'b0, phase = 1'b0;
    int          wr_count = 0;
    logic [31:0] first_addr = '0, prev_addr = '0;
    bit          prev_req = 1'b0, prev_wait = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory responder
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0; mem_err = 1'b0; prev_req = 1'b0; prev_wait = 1'b0;
        end else begin
            if (prev_wait)
                check(mem_req && mem_addr == prev_addr, "R12", "held address", mem_addr, prev_addr);
            if (mem_req && !prev_req) first_addr = mem_addr;
            phase = ~phase;
            if (mem_req && !(stall_en && phase)) begin
                mem_ack   = 1'b1;
                mem_err   = (mem_addr == err_addr) && (mem_we == err_write);
                mem_rdata = mem[mem_addr[8:1]];
                if (mem_we && !mem_err) begin
                    mem[mem_addr[8:1]] = mem_wdata;
                    wr_count++;
                end
            end else begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end
            prev_wait = mem_req && !mem_ack;
            prev_addr = mem_addr;
            prev_req  = mem_req;
        end
    end

    // Cycle-by-cycle reference of the visible context
    always @(negedge clk) begin
        if (rst) begin
            exp_sr = '0; exp_pc = '0; exp_ssp = '0; pend = P_NONE;
        end else begin
            if (done) begin
                check(pend == P_DONE, "R10", "done without expected success", pend, P_DONE);
                exp_sr = pend_sr; exp_pc = pend_pc; exp_ssp = pend_ssp;
                pend = P_NONE;
            end
            if (exc_valid) begin
                check((pend == P_FMT && exc_code == 2'd1) || (pend == P_BUS && exc_code == 2'd2),
                      "R7", "exception code", exc_code, (pend == P_FMT) ? 1 : 2);
                pend = P_NONE;
            end
            check(sr_out == exp_sr && pc_out == exp_pc && ssp_out == exp_ssp,
                  "R10", "context (ssp shown)", ssp_out, exp_ssp);
        end
    end

    task automatic build(input logic [31:0] base, input logic [3:0] fmt, input logic [15:0] sr,
                         input logic [31:0] pc, input logic [15:0] ssw, input logic [7:0] verb);
        for (int i = 0; i < 12; i++) mem[base[8:1] + 8'(i)] = 16'hA000 + 16'(i);
        mem[base[8:1] + 8'd0] = sr;
        mem[base[8:1] + 8'd1] = pc[31:16];
        mem[base[8:1] + 8'd2] = pc[15:0];
        mem[base[8:1] + 8'd3] = {fmt, 12'h0B4};
        mem[base[8:1] + 8'd4] = ssw;
        mem[base[8:1] + 8'd7] = {verb, 8'h3C};
    endtask

    task automatic run_frame(input logic [31:0] base, input bit restart, input logic [31:0] other,
                             input int outcome, input logic [15:0] esr, input logic [31:0] epc,
                             input logic [31:0] essp, input string tag);
        int n;
        pend = outcome; pend_sr = esr; pend_pc = epc; pend_ssp = essp;
        @(negedge clk); start = 1'b1; ssp_in = base; ver_in = OWN_VER;
        @(negedge clk); start = 1'b0;
        if (restart) begin
            @(negedge clk); start = 1'b1; ssp_in = other;
            @(negedge clk); start = 1'b0;
        end
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!(done || exc_valid || halt) && n < 300);
        check(n < 300, tag, "return finished", n, 300);
        @(negedge clk); #1;
    endtask

    initial begin
        int w0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check(sr_out == 0 && pc_out == 0 && ssp_out == 0, "R1", "context after reset", ssp_out, 0);
        check(!done && !exc_valid && !busy && !halt, "R1", "flags after reset",
              {done, exc_valid, busy, halt}, 0);

        // R3: short frame
        build(32'h20, 4'h0, 16'h2704, 32'h0001_2346, 16'h0, OWN_VER);
        run_frame(32'h20, 0, 0, P_DONE, 16'h2704, 32'h0001_2346, 32'h28, "R3");
        check(first_addr == 32'h26, "R2", "first access address", first_addr, 32'h26);
        check(ssp_out == 32'h28 && pc_out == 32'h0001_2346 && sr_out == 16'h2704,
              "R3", "short frame pc", pc_out, 32'h0001_2346);
        check(wr_count == 0, "R6", "no write on short frame", wr_count, 0);

        // R4: long frame with acknowledge stalls
        stall_en = 1'b1;
        build(32'h60, 4'h2, 16'h0011, 32'hCAFE_0010, 16'h0, OWN_VER);
        run_frame(32'h60, 0, 0, P_DONE, 16'h0011, 32'hCAFE_0010, 32'h6C, "R4");
        stall_en = 1'b0;
        check(ssp_out == 32'h6C, "R4", "long frame ssp", ssp_out, 32'h6C);

        // R5: valid bus-fault frame, no write-back
        build(32'hA0, 4'hC, 16'h2010, 32'h0040_0100, 16'h0123, OWN_VER);
        run_frame(32'hA0, 0, 0, P_DONE, 16'h2010, 32'h0040_0100, 32'hB8, "R5");
        check(ssp_out == 32'hB8, "R5", "fault frame ssp", ssp_out, 32'hB8);
        check(wr_count == 0, "R6", "no write without flag", wr_count, 0);

        // R6: bus-fault frame with write-back flag
        build(32'hE0, 4'hC, 16'h2300, 32'h0000_8000, 16'h8321, OWN_VER);
        run_frame(32'hE0, 0, 0, P_DONE, 16'h2300, 32'h0000_8000, 32'hF8, "R6");
        check(mem[8'h74] == 16'h0321, "R6", "rewritten status word", mem[8'h74], 16'h0321);
        check(wr_count == 1, "R6", "one write", wr_count, 1);

        // R2: unknown format
        build(32'h120, 4'h5, 16'h1111, 32'h1111_1111, 16'h8000, OWN_VER);
        run_frame(32'h120, 0, 0, P_FMT, 0, 0, 0, "R2");
        check(first_addr == 32'h126, "R2", "format word read first", first_addr, 32'h126);
        check(ssp_out == 32'hF8 && wr_count == 1, "R9", "state after format error", ssp_out, 32'hF8);

        // R5: version mismatch
        build(32'h140, 4'hC, 16'h2222, 32'h2222_2222, 16'h8001, OWN_VER ^ 8'h01);
        run_frame(32'h140, 0, 0, P_FMT, 0, 0, 0, "R5");
        check(mem[8'hA4] == 16'h8001 && wr_count == 1, "R9", "frame kept after version error",
              mem[8'hA4], 16'h8001);

        // R7: bus error on a read
        build(32'h180, 4'h2, 16'h3333, 32'h3333_3333, 16'h0, OWN_VER);
        err_addr = 32'h184; err_write = 1'b0;
        run_frame(32'h180, 0, 0, P_BUS, 0, 0, 0, "R7");
        err_addr = '1;
        check(ssp_out == 32'hF8 && pc_out == 32'h0000_8000, "R9", "context after bus error",
              pc_out, 32'h0000_8000);

        // R11: start ignored while busy
        build(32'h1A0, 4'h0, 16'h0404, 32'h0BAD_F00D, 16'h0, OWN_VER);
        run_frame(32'h1A0, 1, 32'h20, P_DONE, 16'h0404, 32'h0BAD_F00D, 32'h1A8, "R11");
        check(ssp_out == 32'h1A8, "R11", "first start wins", ssp_out, 32'h1A8);
        repeat (20) @(negedge clk);
        #1;
        check(!busy && ssp_out == 32'h1A8, "R11", "no second return", ssp_out, 32'h1A8);

        // R8: bus error on write-back halts
        build(32'h1C0, 4'hC, 16'h5555, 32'h5555_5555, 16'h8555, OWN_VER);
        err_addr = 32'h1C8; err_write = 1'b1;
        w0 = wr_count;
        run_frame(32'h1C0, 0, 0, P_HALT, 0, 0, 0, "R8");
        check(halt == 1'b1, "R8", "halt raised", halt, 1);
        check(mem[8'hE4] == 16'h8555 && wr_count == w0, "R8", "failed write stored nothing",
              mem[8'hE4], 16'h8555);
        @(negedge clk); start = 1'b1; ssp_in = 32'h20; ver_in = OWN_VER;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        #1;
        check(halt && !busy && !mem_req, "R8", "halted sequencer ignores start",
              {halt, busy, mem_req}, 3'b100);
        err_addr = '1; err_write = 1'b0;

        // R1: reset clears halt and context
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check(!halt && !busy && ssp_out == 0 && pc_out == 0 && sr_out == 0, "R1",
              "state after second reset", {halt, ssp_out}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule